// File: doc/BRIEF.md
# Potentiometer Tap Register with Power-Up Recall

This block keeps the volatile tap code of a digital potentiometer and a volatile control flag, and it mediates access to a byte held in an external non-volatile array that fixes the tap value taken at power-up. After reset the tap code sits at a fixed mid-scale preset. The block then waits for a power-good indication, spends one cycle copying the stored byte into the tap register, and raises a recall-complete flag. Until that flag rises, every bus request is dropped.

A serial bus front end delivers byte-level requests to it: valid, direction, an 11-bit byte address and write data. The block answers only in the top four addresses of that space. The top address is the tap location. The address just below it holds the control byte, whose most significant bit selects volatile-only access. The two addresses below that are reserved. A tap write is applied on the clock edge that presents it, so the front end should present it when the last data bit is shifted in rather than wait for the end of the transfer. When the volatile-only flag is clear, the same write also raises a one-cycle request toward the non-volatile write path. Reads return data one cycle after the request.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While reset is held, and in the first cycles after it until recall starts, the tap code is 0x40, the control flag is 0, recall_done is 0, and both nv_wr_req and rd_valid are 0.
- R2: When pwr_good is first sampled high at a clock edge, the next edge loads bits 6..0 of nv_ivr into the tap code and sets recall_done. Until then the tap code stays 0x40. Once recall_done is set it stays set until reset.
- R3: A request presented while recall_done is 0 has no effect. It changes neither the tap code nor the flag, and it produces no rd_valid and no nv_wr_req.
- R4: A write to 0x7FF while the flag is 1 sets the tap code to bits 6..0 of the data one cycle later, and raises no nv_wr_req.
- R5: A write to 0x7FF while the flag is 0 sets the tap code one cycle later. In that same cycle nv_wr_req is high for exactly one cycle, with nv_wr_data equal to the data with bit 7 cleared.
- R6: A write to 0x7FE whose bits 6..0 are all zero sets the flag to data bit 7.
- R7: A write to 0x7FE with any of bits 6..0 set leaves the flag unchanged.
- R8: A read of 0x7FF gives rd_valid one cycle later. rd_data is {0, tap code} when the flag is 1 and {0, nv_ivr[6:0]} when the flag is 0.
- R9: A read of 0x7FE returns the flag in bit 7 and zeros in bits 6..0.
- R10: Writes to 0x7FC and 0x7FD change neither the tap code nor the flag and raise no nv_wr_req. Reads of them return 0x00 with rd_valid.
- R11: Requests to addresses below 0x7FC raise no rd_valid and have no effect.
- R12: Bit 7 of tap write data is discarded, and bit 7 of every tap readback and of nv_wr_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply is high enough for reliable non-volatile reads |
| nv_ivr | input | 8 | Stored power-up byte from the non-volatile array |
| req_valid | input | 1 | Byte request strobe from the bus front end |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write data |
| tap_code | output | 7 | Wiper position, 0 nearest low terminal |
| recall_done | output | 1 | Power-up recall finished |
| nv_wr_req | output | 1 | One-cycle request to store nv_wr_data |
| nv_wr_data | output | 8 | Byte to store as the power-up value |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The bench first checks the preset window: a write or read issued before recall must be dropped, and a design that let it through would move the wiper off 0x40 or answer the read. It then toggles the volatile-only flag and tests both paths of a tap write. A mis-steered write would either raise a stray store request or skip a needed one, and a read would come back from the wrong source: the live tap value rather than the stored byte, or the other way round. It also sends a control write with a stray low bit set, which a loose decoder would accept and use to flip the flag. Finally it writes and reads the reserved and ordinary addresses, where a decoder that compares too few address bits would alias them onto the tap or control locations.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Which of the decoded byte locations a request targets
  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_RSVD,
    RGN_CTRL,
    RGN_TAP
  } rgn_e;

  // Power-up recall sequence
  typedef enum logic [1:0] {
    RC_PRESET,
    RC_LOAD,
    RC_READY
  } rc_state_e;

endpackage

// File: rtl/wiper_decode.sv
module wiper_decode
  import wiper_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn
);

  localparam int HI_W = ADDR_W - 2;

  logic in_window;

  assign in_window = (addr[ADDR_W-1:2] == {HI_W{1'b1}});

  always_comb begin
    rgn = RGN_NONE;
    if (in_window) begin
      unique case (addr[1:0])
        2'b11:   rgn = RGN_TAP;
        2'b10:   rgn = RGN_CTRL;
        default: rgn = RGN_RSVD;
      endcase
    end
  end

endmodule

// File: rtl/wiper_recall.sv
module wiper_recall
  import wiper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic load_en,
  output logic done
);

  rc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RC_PRESET: if (pwr_good) state_d = RC_LOAD;
      RC_LOAD:   state_d = RC_READY;
      default:   state_d = RC_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RC_PRESET;
    else        state_q <= state_d;
  end

  assign load_en = (state_q == RC_LOAD);
  assign done    = (state_q == RC_READY);

endmodule

// File: rtl/wiper_rdmux.sv
module wiper_rdmux
  import wiper_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAP_W  = 7
) (
  input  rgn_e              rgn,
  input  logic              vol_only,
  input  logic [TAP_W-1:0]  tap,
  input  logic [DATA_W-1:0] nv_byte,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int PAD_W = DATA_W - TAP_W;

  always_comb begin
    unique case (rgn)
      RGN_TAP:  rd_byte = vol_only ? {{PAD_W{1'b0}}, tap}
                                   : {{PAD_W{1'b0}}, nv_byte[TAP_W-1:0]};
      RGN_CTRL: rd_byte = {vol_only, {(DATA_W-1){1'b0}}};
      default:  rd_byte = '0;
    endcase
  end

endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wiper_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int TAP_W  = 7,
  parameter int PRESET = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [DATA_W-1:0] nv_ivr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [TAP_W-1:0]  tap_code,
  output logic              recall_done,
  output logic              nv_wr_req,
  output logic [DATA_W-1:0] nv_wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - TAP_W;
  localparam logic [TAP_W-1:0] PRESET_CODE = TAP_W'(PRESET);

  rgn_e              rgn;
  logic              load_en;
  logic              accept;
  logic              wr_tap;
  logic              wr_ctrl;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_byte;

  logic [TAP_W-1:0]  tap_q, tap_d;
  logic              flag_q, flag_d;
  logic              nvw_q, nvw_d;
  logic [DATA_W-1:0] nvd_q, nvd_d;
  logic              rdv_q, rdv_d;
  logic [DATA_W-1:0] rdd_q, rdd_d;

  wiper_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .rgn  (rgn)
  );

  wiper_recall u_recall (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .load_en  (load_en),
    .done     (recall_done)
  );

  wiper_rdmux #(.DATA_W(DATA_W), .TAP_W(TAP_W)) u_rdmux (
    .rgn      (rgn),
    .vol_only (flag_q),
    .tap      (tap_q),
    .nv_byte  (nv_ivr),
    .rd_byte  (rd_byte)
  );

  // Request qualification: nothing is honoured before recall completes
  assign accept  = req_valid && recall_done;
  assign wr_tap  = accept && req_write && (rgn == RGN_TAP);
  assign wr_ctrl = accept && req_write && (rgn == RGN_CTRL)
                   && (req_wdata[DATA_W-2:0] == '0);
  assign rd_hit  = accept && !req_write && (rgn != RGN_NONE);

  always_comb begin
    tap_d  = tap_q;
    flag_d = flag_q;
    nvw_d  = 1'b0;
    nvd_d  = nvd_q;
    rdv_d  = rd_hit;
    rdd_d  = rdd_q;
    if (load_en) begin
      tap_d = nv_ivr[TAP_W-1:0];
    end else if (wr_tap) begin
      tap_d = req_wdata[TAP_W-1:0];
    end
    if (wr_ctrl) begin
      flag_d = req_wdata[DATA_W-1];
    end
    if (wr_tap && !flag_q) begin
      nvw_d = 1'b1;
      nvd_d = {{PAD_W{1'b0}}, req_wdata[TAP_W-1:0]};
    end
    if (rd_hit) begin
      rdd_d = rd_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= PRESET_CODE;
      flag_q <= 1'b0;
      nvw_q  <= 1'b0;
      nvd_q  <= '0;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
    end else begin
      tap_q  <= tap_d;
      flag_q <= flag_d;
      nvw_q  <= nvw_d;
      nvd_q  <= nvd_d;
      rdv_q  <= rdv_d;
      rdd_q  <= rdd_d;
    end
  end

  assign tap_code   = tap_q;
  assign nv_wr_req  = nvw_q;
  assign nv_wr_data = nvd_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;

endmodule

// File: rtl/wiper_tap_ctrl_chk.sv
module wiper_tap_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int TAP_W  = 7,
  parameter int PRESET = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [TAP_W-1:0]  tap_code,
  input logic              recall_done,
  input logic              nv_wr_req,
  input logic [DATA_W-1:0] nv_wr_data,
  input logic              rd_valid
);

  localparam logic [TAP_W-1:0] PRESET_CODE = TAP_W'(PRESET);
  localparam int HI_W = ADDR_W - 2;

  // R2 / R3: wiper holds the preset until recall has finished
  p_preset_until_recall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_done |-> tap_code == PRESET_CODE);

  // R2: recall completion is sticky
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done |=> recall_done);

  // R5: a store request only follows an accepted tap write
  p_nvreq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_req |-> $past(req_valid && req_write && recall_done
                        && req_addr == {ADDR_W{1'b1}}));

  // R10: without a tap write the wiper does not move after recall
  p_tap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_done && !(req_valid && req_write && req_addr == {ADDR_W{1'b1}}))
      |=> $stable(tap_code));

  // R11: read data only answers reads inside the top window
  p_rdvalid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write && recall_done
                       && req_addr[ADDR_W-1:2] == {HI_W{1'b1}}));

  // R12: stored byte never carries a set top bit
  p_nv_msb_r12: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_req |-> !nv_wr_data[DATA_W-1]);

endmodule

bind wiper_tap_ctrl wiper_tap_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TAP_W  (TAP_W),
  .PRESET (PRESET)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .tap_code    (tap_code),
  .recall_done (recall_done),
  .nv_wr_req   (nv_wr_req),
  .nv_wr_data  (nv_wr_data),
  .rd_valid    (rd_valid)
);

// File: tb/wiper_tap_ctrl_bench.sv
module wiper_tap_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        pwr_good;
  logic [7:0]  nv_ivr;
  logic        req_valid;
  logic        req_write;
  logic [10:0] req_addr;
  logic [7:0]  req_wdata;
  logic [6:0]  tap_code;
  logic        recall_done;
  logic        nv_wr_req;
  logic [7:0]  nv_wr_data;
  logic        rd_valid;
  logic [7:0]  rd_data;

  wiper_tap_ctrl u_wiper_tap_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .nv_ivr      (nv_ivr),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .tap_code    (tap_code),
    .recall_done (recall_done),
    .nv_wr_req   (nv_wr_req),
    .nv_wr_data  (nv_wr_data),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural non-volatile array: commits a store request one edge later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)         nv_ivr <= 8'hA5;
    else if (nv_wr_req) nv_ivr <= nv_wr_data;
  end

  typedef struct {
    string      tag;
    logic [6:0] tap;
    logic       done;
    logic       rdv;
    logic [7:0] rdd;
    logic       nvw;
    logic [7:0] nvd;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 1'b0;

  logic [6:0] tap_m;
  logic       flag_m;
  logic       done_m;
  logic [7:0] ivr_m;

  // Monitor: pops one expected item per cycle and compares all outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (tap_code !== e.tap) begin
        miscompares++;
        $display("FAIL %s tap_code act %h exp %h", e.tag, tap_code, e.tap);
      end
      if (recall_done !== e.done) begin
        miscompares++;
        $display("FAIL %s recall_done act %b exp %b", e.tag, recall_done, e.done);
      end
      if (rd_valid !== e.rdv) begin
        miscompares++;
        $display("FAIL %s rd_valid act %b exp %b", e.tag, rd_valid, e.rdv);
      end else if (e.rdv && rd_data !== e.rdd) begin
        miscompares++;
        $display("FAIL %s rd_data act %h exp %h", e.tag, rd_data, e.rdd);
      end
      if (nv_wr_req !== e.nvw) begin
        miscompares++;
        $display("FAIL %s nv_wr_req act %b exp %b", e.tag, nv_wr_req, e.nvw);
      end else if (e.nvw && nv_wr_data !== e.nvd) begin
        miscompares++;
        $display("FAIL %s nv_wr_data act %h exp %h", e.tag, nv_wr_data, e.nvd);
      end
    end
  end

  function automatic exp_t base_exp(string tag);
    exp_t e;
    e.tag = tag; e.tap = tap_m; e.done = done_m;
    e.rdv = 1'b0; e.rdd = 8'h00; e.nvw = 1'b0; e.nvd = 8'h00;
    return e;
  endfunction

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b0;
    e = base_exp(tag);
    @(posedge clk); #1;
    exp_q.push_back(e);
  endtask

  // Driver: applies one request and pushes the outputs expected after it
  task automatic op(input bit wr, input logic [10:0] a, input logic [7:0] d,
                    input string tag);
    exp_t e;
    logic store;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    store = 1'b0;
    e = base_exp(tag);
    if (done_m) begin
      if (wr) begin
        if (a == 11'h7FF) begin
          tap_m = d[6:0];
          if (!flag_m) begin
            e.nvw = 1'b1; e.nvd = {1'b0, d[6:0]}; store = 1'b1;
          end
        end else if (a == 11'h7FE && d[6:0] == 7'd0) begin
          flag_m = d[7];
        end
      end else if (a >= 11'h7FC) begin
        e.rdv = 1'b1;
        if (a == 11'h7FF)      e.rdd = flag_m ? {1'b0, tap_m} : {1'b0, ivr_m[6:0]};
        else if (a == 11'h7FE) e.rdd = {flag_m, 7'd0};
        else                   e.rdd = 8'h00;
      end
    end
    e.tap = tap_m;
    @(posedge clk); #1;
    req_valid = 1'b0;
    exp_q.push_back(e);
    if (store) begin
      ivr_m = e.nvd;
      idle({tag, " settle"});
    end
  endtask

  task automatic recall();
    exp_t e;
    @(negedge clk);
    pwr_good = 1'b1;
    e = base_exp("R2 load cycle");
    @(posedge clk); #1;
    exp_q.push_back(e);
    @(negedge clk);
    @(posedge clk); #1;
    done_m = 1'b1;
    tap_m  = ivr_m[6:0];
    exp_q.push_back(base_exp("R2 recalled"));
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    tap_m = 7'h40; flag_m = 1'b0; done_m = 1'b0; ivr_m = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    idle("R1 preset hold");
    op(1'b1, 11'h7FF, 8'h11, "R3 write before recall");
    op(1'b0, 11'h7FF, 8'h00, "R3 read before recall");
    op(1'b1, 11'h7FE, 8'h80, "R3 ctrl before recall");
    recall();
    op(1'b0, 11'h7FF, 8'h00, "R8 read stored byte, flag 0");
    op(1'b0, 11'h7FE, 8'h00, "R9 read ctrl flag 0");
    op(1'b1, 11'h7FF, 8'h93, "R5 R12 write tap+store");
    op(1'b0, 11'h7FF, 8'h00, "R8 R12 read stored after write");
    op(1'b1, 11'h7FE, 8'h81, "R7 ctrl with low bit set");
    op(1'b0, 11'h7FE, 8'h00, "R7 flag still 0");
    op(1'b1, 11'h7FE, 8'hC0, "R7 ctrl with bit 6 set");
    op(1'b1, 11'h7FE, 8'h80, "R6 set volatile-only flag");
    op(1'b0, 11'h7FE, 8'h00, "R9 read ctrl flag 1");
    op(1'b1, 11'h7FF, 8'hFF, "R4 R12 volatile write 0x7F");
    op(1'b0, 11'h7FF, 8'h00, "R8 R12 read live tap");
    op(1'b1, 11'h7FF, 8'h00, "R4 volatile write 0x00");
    op(1'b1, 11'h7FF, 8'h2A, "R4 back-to-back volatile write");
    op(1'b1, 11'h7FC, 8'h55, "R10 write reserved 7FC");
    op(1'b1, 11'h7FD, 8'hFF, "R10 write reserved 7FD");
    op(1'b0, 11'h7FC, 8'h00, "R10 read reserved 7FC");
    op(1'b0, 11'h7FD, 8'h00, "R10 read reserved 7FD");
    op(1'b1, 11'h3FF, 8'h7E, "R11 write outside window");
    op(1'b1, 11'h7FB, 8'h01, "R11 write just below window");
    op(1'b0, 11'h7FB, 8'h00, "R11 read just below window");
    op(1'b0, 11'h000, 8'h00, "R11 read address zero");
    op(1'b0, 11'h7FF, 8'h00, "R8 tap unchanged by others");
    op(1'b1, 11'h7FE, 8'h00, "R6 clear flag");
    op(1'b0, 11'h7FF, 8'h00, "R8 read stored byte again");
    op(1'b1, 11'h7FF, 8'h05, "R5 second store");
    op(1'b1, 11'h7FF, 8'h06, "R5 third store");
    op(1'b0, 11'h7FF, 8'h00, "R8 read latest stored");
    pwr_good = 1'b0;
    idle("R2 done stays after pwr_good drop");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule